// File: doc/BRIEF.md
# Buffered Compare PWM Timer Channel

This block is a single up-counting timer channel that produces one pulse-width-modulated output from two compare values. A match on the first compare value drives the output high and a match on the second drives it low, so the pair together sets the duty cycle. The counter can run freely and wrap, or it can return to zero on either compare match, which fixes the period.

The first compare value is double-buffered. Software writes a shadow register at any time, and the shadow moves into the active compare value only at a chosen moment. A mode bit selects that moment: either the first compare match itself, or any event that returns the counter to zero. Those events are a wrap past the top count, a software write of zero while running, and a clear by the selected compare match. Because of this, a duty change written mid-period never produces a glitch or a half-updated period.

Registers are loaded through a plain one-cycle write port. The `run` input gates counting. The output pin and a one-cycle match pulse are the only results. None of these pins carries a data stream, so none has a valid/ready handshake: a write is taken on any clock edge where `wr_en` is high.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the counter, compare A, compare B and the shadow all hold zero, transfer mode is 0, the clear field is 00, and `pwm_out` and `match_flag` are low.
- R2: While `run` is low the counter holds its value and no compare match, output change or transfer occurs; while `run` is high the counter advances by one per clock.
- R3: A compare match is the counter equalling a compare value at a clock edge with `run` high. On that edge a match on A drives `pwm_out` high and a match on B drives it low. When both match on the same edge, the output goes low.
- R4: Control bits [2:1] select the clear source: 00 free-running, 01 clear on compare A, 10 clear on compare B, 11 free-running. A selected match loads zero into the counter on the edge of the match.
- R5: A write to the shadow (address 3) never changes the active compare A by itself.
- R6: With control bit 0 equal to 0, the shadow is copied into compare A on every compare-A match edge.
- R7: With control bit 0 equal to 1, the shadow is copied into compare A on each clear by the selected clear source.
- R8: With control bit 0 equal to 1, the shadow is copied into compare A when the counter wraps from all ones to zero.
- R9: With control bit 0 equal to 1, a write of zero to the counter (address 0) copies the shadow into compare A if `run` is high, and does not copy it if `run` is low.
- R10: A write to control (address 4) while `run` is high leaves bit 0 unchanged. Bits [2:1] are taken at any time.
- R11: When a shadow write and a transfer fall on the same edge, compare A receives the value being written.
- R12: `match_flag` is high for the one cycle after each edge on which a compare A or compare B match occurs, and low otherwise.
- R13: A write to the counter (address 0) loads the written value on that edge and takes priority over counting and clearing. Address 1 is compare A and address 2 is compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per edge |
| wr_addr | input | ADDR_W (3) | 0 counter, 1 compare A, 2 compare B, 3 shadow, 4 control |
| wr_data | input | CNT_W (16) | Write data; control uses bits [2:0] |
| run | input | 1 | Counting enable |
| pwm_out | output | 1 | PWM output pin |
| match_flag | output | 1 | One-cycle pulse after any compare match |

## Verification
Every result is registered on the same edge that samples the matching counter value. The output level, the match pulse and a counter clear or shadow transfer are therefore all visible one edge after the counter reaches the compare value. A transfer first shows up at the next compare-A match that uses the new value. The bench counts rising edges from the first enabled one. It turns each requirement into an expected output level at a given edge number, and queues these in time order. A monitor on the falling edge takes the entries whose edge number has arrived and compares them. Because sampling never happens at the active edge, the result does not depend on process order.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  // Counter clear source selection (control bits [2:1])
  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSVD = 2'b11
  } clr_sel_e;

  // Register map of the write port
  typedef enum logic [2:0] {
    REG_COUNT  = 3'd0,
    REG_CMPA   = 3'd1,
    REG_CMPB   = 3'd2,
    REG_SHADOW = 3'd3,
    REG_CTRL   = 3'd4
  } reg_addr_e;

  // Control register layout: {clr_sel, xfer_on_clear}
  typedef struct packed {
    clr_sel_e clr_sel;
    logic     xfer_on_clear;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              run,
  input  logic              xfer,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output ctrl_t             ctrl
);

  logic sel_a, sel_b, sel_c, sel_ctl;
  logic [CNT_W-1:0] shadow_q, cmp_a_q, cmp_b_q, xfer_val;
  ctrl_t ctrl_q, ctrl_wr;

  assign sel_a   = wr_en && (wr_addr == ADDR_W'(REG_CMPA));
  assign sel_b   = wr_en && (wr_addr == ADDR_W'(REG_CMPB));
  assign sel_c   = wr_en && (wr_addr == ADDR_W'(REG_SHADOW));
  assign sel_ctl = wr_en && (wr_addr == ADDR_W'(REG_CTRL));

  // A shadow write on the transfer edge is forwarded straight through
  assign xfer_val = sel_c ? wr_data : shadow_q;
  assign ctrl_wr  = ctrl_t'(wr_data[CTRL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
      ctrl_q   <= '{clr_sel: CLR_NONE, xfer_on_clear: 1'b0};
    end else begin
      if (sel_c) shadow_q <= wr_data;
      if (sel_b) cmp_b_q  <= wr_data;
      if (xfer)       cmp_a_q <= xfer_val;
      else if (sel_a) cmp_a_q <= wr_data;
      if (sel_ctl) begin
        ctrl_q.clr_sel <= ctrl_wr.clr_sel;
        if (!run) ctrl_q.xfer_on_clear <= ctrl_wr.xfer_on_clear;
      end
    end
  end

  assign cmp_a = cmp_a_q;
  assign cmp_b = cmp_b_q;
  assign ctrl  = ctrl_q;

  // R5: active compare A moves only on a transfer or a direct write
  assert_a_only_on_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !sel_a) |=> $stable(cmp_a_q))
    else $error("R5: compare A changed without transfer");

  // R10: transfer mode frozen while running
  assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(ctrl_q.xfer_on_clear))
    else $error("R10: mode bit changed while running");

  // R11: same-edge shadow write is what lands in compare A
  assert_xfer_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && sel_c) |=> (cmp_a_q == $past(wr_data)))
    else $error("R11: bypassed shadow value not transferred");

endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  ctrl_t            ctrl,
  output logic             match_a,
  output logic             match_b,
  output logic             xfer
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic clr_hit, clr_evt, wrap_evt, zero_wr_evt;

  assign match_a = run && (cnt_q == cmp_a);
  assign match_b = run && (cnt_q == cmp_b);

  always_comb begin
    unique case (ctrl.clr_sel)
      CLR_ON_A: clr_hit = match_a;
      CLR_ON_B: clr_hit = match_b;
      default:  clr_hit = 1'b0;
    endcase
  end

  // Events that return the counter to zero
  assign clr_evt     = clr_hit && !cnt_wr;
  assign wrap_evt    = run && !cnt_wr && !clr_hit && (cnt_q == CNT_TOP);
  assign zero_wr_evt = run && cnt_wr && (wr_data == '0);

  assign xfer = ctrl.xfer_on_clear ? (clr_evt || wrap_evt || zero_wr_evt) : match_a;

  always_comb begin
    if (cnt_wr)       cnt_d = wr_data;
    else if (!run)    cnt_d = cnt_q;
    else if (clr_hit) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: stopped counter holds
  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q))
    else $error("R2: counter moved while stopped");

  // R2: no matches while stopped
  assert_no_match_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!match_a && !match_b && !xfer))
    else $error("R2: match or transfer while stopped");

  // R4: selected compare match returns counter to zero
  assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (cnt_q == '0))
    else $error("R4: counter not cleared");

  // R13: a counter write loads the value
  assert_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data)))
    else $error("R13: counter load lost");

endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic match_a,
  input  logic match_b,
  output logic pwm,
  output logic flag
);

  logic pwm_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= match_a || match_b;
      if (match_b)      pwm_q <= 1'b0;
      else if (match_a) pwm_q <= 1'b1;
    end
  end

  assign pwm  = pwm_q;
  assign flag = flag_q;

  assert_set_on_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && !match_b) |=> pwm_q)
    else $error("R3: output not set on compare A");

  assert_clr_on_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> !pwm_q)
    else $error("R3: output not cleared on compare B");

  assert_flag_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_a && !match_b) |=> !flag_q)
    else $error("R12: flag without match");

endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              run,
  output logic              pwm_out,
  output logic              match_flag
);

  logic [CNT_W-1:0] cmp_a, cmp_b;
  ctrl_t ctrl;
  logic match_a, match_b, xfer, cnt_wr;

  assign cnt_wr = wr_en && (wr_addr == ADDR_W'(REG_COUNT));

  pwm_tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .xfer(xfer),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .ctrl(ctrl)
  );

  pwm_tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_wr(cnt_wr),
    .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .ctrl(ctrl),
    .match_a(match_a), .match_b(match_b), .xfer(xfer)
  );

  pwm_tmr_wave u_wave (
    .clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .pwm(pwm_out), .flag(match_flag)
  );

  // R6: in compare-match mode every compare-A match transfers
  assert_xfer_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.xfer_on_clear && match_a) |-> xfer)
    else $error("R6: missing transfer on compare A");

endmodule

// File: tb/pwm_cmp_timer_tb_top.sv
module pwm_cmp_timer_tb_top;

  localparam logic [2:0] A_CNT = 3'd0;
  localparam logic [2:0] A_CMPA = 3'd1;
  localparam logic [2:0] A_CMPB = 3'd2;
  localparam logic [2:0] A_SHD = 3'd3;
  localparam logic [2:0] A_CTL = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic run = 1'b0;
  logic pwm_out, match_flag;

  int edge_n = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    is_flag;
    bit    val;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t item;

  always #2 clk = ~clk;

  always @(posedge clk) edge_n <= edge_n + 1;

  pwm_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .pwm_out(pwm_out), .match_flag(match_flag)
  );

  function automatic void chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b (edge %0d)", tag, act, exp, edge_n);
    end
  endfunction

  // Monitor: pop expectations whose edge has arrived
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= edge_n) begin
      item = sb_q.pop_front();
      if (item.at < edge_n) begin
        n_chk++; n_err++;
        $display("FAIL %s actual=missed expected=edge %0d", item.tag, item.at);
      end else if (item.is_flag) chk(item.tag, match_flag, item.val);
      else chk(item.tag, pwm_out, item.val);
    end
  end

  task automatic expect_pwm(int at, bit v, string tag);
    sb_q.push_back('{at: at, is_flag: 1'b0, val: v, tag: tag});
  endtask

  task automatic expect_flag(int at, bit v, string tag);
    sb_q.push_back('{at: at, is_flag: 1'b1, val: v, tag: tag});
  endtask

  task automatic wait_edge(int n);
    while (edge_n < n) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic drain();
    while (sb_q.size() > 0) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset();
    run = 1'b0; wr_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Write that takes effect on edge e
  task automatic wr_at(int e, logic [2:0] a, logic [15:0] d);
    wait_edge(e - 1);
    wr(a, d);
  endtask

  task automatic setup(logic [15:0] a, logic [15:0] b, logic [15:0] c,
                       logic [2:0] ctl, logic [15:0] cnt);
    wr(A_CTL, {13'd0, ctl});
    wr(A_CMPA, a);
    wr(A_CMPB, b);
    wr(A_SHD, c);
    wr(A_CNT, cnt);
  endtask

  task automatic start(output int e0);
    e0 = edge_n + 1;
    run = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int e0;
    int e1;
    int s;

    // R1: reset state and zeroed compare registers
    do_reset();
    chk("R1 pwm after reset", pwm_out, 1'b0);
    chk("R1 flag after reset", match_flag, 1'b0);
    start(e0);
    expect_pwm(e0, 1'b0, "R1 both zero compares, low wins");
    expect_flag(e0, 1'b1, "R1 zero counter matches zero compares");
    expect_flag(e0 + 1, 1'b0, "R1 no match on next count");
    drain();

    // Scenario A: clear on B, period and stop behaviour (R2 R3 R4 R12 R13)
    do_reset();
    setup(16'd5, 16'd10, 16'd5, 3'b100, 16'd0);
    start(e0);
    expect_pwm(e0 + 4, 1'b0, "R3 low before compare A");
    expect_pwm(e0 + 5, 1'b1, "R3 high at compare A");
    expect_flag(e0 + 5, 1'b1, "R12 flag on compare A");
    expect_flag(e0 + 6, 1'b0, "R12 flag one cycle");
    expect_pwm(e0 + 9, 1'b1, "R3 high until compare B");
    expect_pwm(e0 + 10, 1'b0, "R3 low at compare B");
    expect_flag(e0 + 10, 1'b1, "R12 flag on compare B");
    expect_pwm(e0 + 15, 1'b0, "R4 cleared on B, no early A");
    expect_pwm(e0 + 16, 1'b1, "R4 period restarts after clear on B");
    wait_edge(e0 + 21);
    run = 1'b0;
    wr(A_CNT, 16'd3);
    s = edge_n;
    expect_flag(s + 2, 1'b0, "R2 no match while stopped");
    expect_pwm(s + 4, 1'b0, "R2 output holds while stopped");
    expect_flag(s + 6, 1'b0, "R2 no match while stopped later");
    drain();
    start(e1);
    expect_pwm(e1 + 1, 1'b0, "R13 loaded count 3, not yet at A");
    expect_pwm(e1 + 2, 1'b1, "R13 loaded count reaches A after two edges");
    drain();

    // Scenario B: mode 0, shadow write mid-period (R5 R6)
    do_reset();
    setup(16'd5, 16'd10, 16'd5, 3'b100, 16'd0);
    start(e0);
    expect_pwm(e0 + 4, 1'b0, "R5 low before old compare A");
    expect_pwm(e0 + 5, 1'b1, "R5 shadow write did not change A");
    expect_pwm(e0 + 17, 1'b0, "R6 new A not yet reached");
    expect_pwm(e0 + 18, 1'b1, "R6 transfer at compare A match");
    wr_at(e0 + 2, A_SHD, 16'd7);
    drain();

    // Scenario C: mode 1, transfer at clear on B (R7)
    do_reset();
    setup(16'd5, 16'd10, 16'd5, 3'b101, 16'd0);
    start(e0);
    expect_pwm(e0 + 5, 1'b1, "R7 first period uses A=5");
    expect_pwm(e0 + 16, 1'b0, "R7 no transfer at compare A");
    expect_pwm(e0 + 18, 1'b1, "R7 transfer at clear on B");
    wr_at(e0 + 6, A_SHD, 16'd7);
    drain();

    // Scenario D: mode 1, overflow transfer (R8, R13 load)
    do_reset();
    setup(16'd3, 16'hFFF8, 16'd8, 3'b001, 16'hFFFA);
    start(e0);
    expect_pwm(e0 + 9, 1'b0, "R8 old A=3 replaced at wrap");
    expect_pwm(e0 + 13, 1'b0, "R8 low before new A");
    expect_pwm(e0 + 14, 1'b1, "R8 new A=8 after wrap");
    drain();

    // Scenario E: mode 1, zero write transfer (R9)
    do_reset();
    setup(16'h0010, 16'h0030, 16'd4, 3'b001, 16'd0);
    start(e0);
    expect_pwm(e0 + 4, 1'b0, "R9 stopped zero write did not transfer");
    expect_pwm(e0 + 7, 1'b0, "R9 low before new A");
    expect_pwm(e0 + 8, 1'b1, "R9 running zero write transferred");
    wr_at(e0 + 3, A_CNT, 16'd0);
    drain();

    // Scenario F: mode write while running ignored (R10)
    do_reset();
    setup(16'd5, 16'd10, 16'd5, 3'b100, 16'd0);
    start(e0);
    expect_pwm(e0 + 5, 1'b1, "R10 first compare A");
    expect_pwm(e0 + 10, 1'b0, "R10 clear source still B");
    expect_pwm(e0 + 16, 1'b1, "R10 mode stayed 0, A=5 kept");
    wr_at(e0 + 2, A_CTL, 16'd5);
    wr_at(e0 + 6, A_SHD, 16'd7);
    drain();

    // Scenario G: shadow write on transfer edge (R11)
    do_reset();
    setup(16'd5, 16'd10, 16'd5, 3'b100, 16'd0);
    start(e0);
    expect_pwm(e0 + 5, 1'b1, "R11 compare A with old value");
    expect_pwm(e0 + 16, 1'b0, "R11 old shadow not transferred");
    expect_pwm(e0 + 18, 1'b0, "R11 low before A=8");
    expect_pwm(e0 + 19, 1'b1, "R11 written value transferred");
    wr_at(e0 + 5, A_SHD, 16'd8);
    drain();

    // Scenario H: both match, clear on A (R3 R4 R12)
    do_reset();
    setup(16'd4, 16'd4, 16'd4, 3'b010, 16'd0);
    start(e0);
    expect_pwm(e0 + 4, 1'b0, "R3 simultaneous A and B leaves low");
    expect_flag(e0 + 4, 1'b1, "R12 flag on simultaneous match");
    expect_flag(e0 + 8, 1'b0, "R4 no match mid period");
    expect_flag(e0 + 9, 1'b1, "R4 clear on A gives period 5");
    drain();

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule